// File: doc/BRIEF.md
# Transceiver Sleep/Wake Sequencer

This block moves a radio transceiver between its active alert condition and a low-power sleep condition. It does so by running a fixed recipe of register accesses over a simple register port. On a sleep command it first locks out the receive and transmit VCO calibrations. It then pulses the transceiver through its full-duplex state to flush the datapath, waiting a counted number of divided sample-clock periods. After the flush it drops back to the wait state and stops the transceiver clocks.

On a wake command it restarts the clocks from an external reference. It then polls the PLL status register until the lock bit reads one, forces the alert state and releases the calibration lockout. The poll has a bounded attempt count. If lock never appears, the block abandons the wake, raises an error flag and still reports the sequence as finished.

Register contents in the transceiver persist across sleep, so the recipe touches only the registers it needs. The serial protocol under the register port, the calibration routines and any power-amplifier control are handled elsewhere.

Top module: `trx_sleep_sequencer`

## Requirements
- R1: After reset the block is idle: `busy`=0, `done`=0, `wake_err`=0, `reg_valid`=0 and `pwr_state`=2'b00. The `pwr_state` encoding is 00 awake, 01 entering sleep, 10 asleep, 11 waking.
- R2: A sleep command issues exactly these writes, in this order, as (address, data): (0x230,0x55), (0x270,0x55), (0x014,0x00), (0x014,0x20), then the flush wait, then (0x014,0x00), (0x009,0x00). The block then ends in `pwr_state`=10.
- R3: After the (0x014,0x20) write completes, the next access is not issued until FLUSH_DIV*FLUSH_PERIODS (default 64*6=384) cycles with `smp_ce` high have been counted. Cycles with `smp_ce` low do not count toward the flush.
- R4: A wake command issues the write (0x009,0x17). It then issues reads of 0x05E until a read returns bit 7 = 1, ignoring all other bits. It then issues the writes (0x014,0x05), (0x230,0x54), (0x270,0x54) and ends in `pwr_state`=00.
- R5: If POLL_MAX reads of 0x05E all return bit 7 = 0, no further access is issued. `done` pulses with `wake_err`=1 and `pwr_state` returns to 10. `wake_err` stays set until the next wake command is accepted, which clears it. A lock seen on exactly the last allowed read counts as success.
- R6: `reg_valid` stays high, with `reg_addr`, `reg_wdata` and `reg_write` held stable, until a cycle in which `reg_ready` is high. Only one access is outstanding at a time, and `reg_valid` is low whenever `busy` is low. `reg_write`=1 marks a write and 0 marks a read.
- R7: A sleep command is ignored unless `pwr_state` is 00. A wake command is ignored unless `pwr_state` is 10.
- R8: Sleep and wake commands that arrive while `busy` is high have no effect on the access sequence or on the final state.
- R9: Each finished sequence, whether it succeeds or fails, gives a `done` pulse exactly one cycle wide. That pulse comes in the cycle after the last handshake, with `busy` already low. `busy` is high exactly while `pwr_state` is 01 or 11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sleep_req | input | 1 | Sleep command pulse |
| wake_req | input | 1 | Wake command pulse |
| smp_ce | input | 1 | Sample-clock enable used to time the flush |
| reg_valid | output | 1 | Register access request |
| reg_write | output | 1 | 1 = write, 0 = read |
| reg_addr | output | 10 | Register address |
| reg_wdata | output | 8 | Write data |
| reg_ready | input | 1 | Access accepted/completed this cycle |
| reg_rdata | input | 8 | Read data, valid with `reg_ready` |
| busy | output | 1 | A sequence is running |
| done | output | 1 | One-cycle pulse when a sequence finishes |
| pwr_state | output | 2 | Tracked power state (00 awake, 01 entering, 10 asleep, 11 waking) |
| wake_err | output | 1 | Last wake failed to see PLL lock |

## Verification
The sequences are swept over every register-port latency from 0 to 3 wait cycles, crossed with lock arriving on the 1st through 4th poll. This shows whether the handshake hold logic and the poll loop are independent of slave timing. It also exposes off-by-one errors at the attempt limit.

The flush is run with `smp_ce` tied high and with `smp_ce` at a third rate. A continuous enable gives an exact count of enable cycles between the two bracketing writes. The sparse enable shows whether the wait follows enable pulses rather than raw clock cycles.

Three other cases are run. A lock that never comes must end with the error flag and no trailing writes, while a lock on the final allowed read must succeed. Commands are injected mid-sequence and in the wrong state, which must leave the logged access stream unchanged.

// File: rtl/trx_seq_pkg.sv
package trx_seq_pkg;

  localparam int ADDR_W = 10;
  localparam int DATA_W = 8;

  // register addresses and the lock flag position in the status register
  localparam logic [ADDR_W-1:0] RA_CAL_RX = 10'h230;
  localparam logic [ADDR_W-1:0] RA_CAL_TX = 10'h270;
  localparam logic [ADDR_W-1:0] RA_MODE   = 10'h014;
  localparam logic [ADDR_W-1:0] RA_CLKS   = 10'h009;
  localparam logic [ADDR_W-1:0] RA_PLLSTS = 10'h05E;
  localparam int LOCK_BIT = 7;

  localparam int NSTEPS     = 12;
  localparam int STEP_W     = $clog2(NSTEPS);
  localparam int WAKE_FIRST = 7;

  typedef enum logic [1:0] {OP_WR = 2'd0, OP_WAIT = 2'd1, OP_POLL = 2'd2} op_e;

  typedef enum logic [1:0] {
    PS_AWAKE    = 2'b00,
    PS_ENTERING = 2'b01,
    PS_ASLEEP   = 2'b10,
    PS_WAKING   = 2'b11
  } pstate_e;

  typedef struct packed {
    op_e               op;
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] data;
    logic              last;
  } step_t;

  function automatic step_t mk(op_e op, logic [ADDR_W-1:0] a, logic [DATA_W-1:0] d, logic l);
    step_t s;
    s.op = op; s.addr = a; s.data = d; s.last = l;
    return s;
  endfunction

  // recipe: steps 0..6 enter sleep, steps 7..11 leave it
  function automatic step_t seq_step(logic [STEP_W-1:0] idx);
    case (idx)
      4'd0:    return mk(OP_WR,   RA_CAL_RX, 8'h55, 1'b0);
      4'd1:    return mk(OP_WR,   RA_CAL_TX, 8'h55, 1'b0);
      4'd2:    return mk(OP_WR,   RA_MODE,   8'h00, 1'b0);
      4'd3:    return mk(OP_WR,   RA_MODE,   8'h20, 1'b0);
      4'd4:    return mk(OP_WAIT, '0,        8'h00, 1'b0);
      4'd5:    return mk(OP_WR,   RA_MODE,   8'h00, 1'b0);
      4'd6:    return mk(OP_WR,   RA_CLKS,   8'h00, 1'b1);
      4'd7:    return mk(OP_WR,   RA_CLKS,   8'h17, 1'b0);
      4'd8:    return mk(OP_POLL, RA_PLLSTS, 8'h00, 1'b0);
      4'd9:    return mk(OP_WR,   RA_MODE,   8'h05, 1'b0);
      4'd10:   return mk(OP_WR,   RA_CAL_RX, 8'h54, 1'b0);
      4'd11:   return mk(OP_WR,   RA_CAL_TX, 8'h54, 1'b1);
      default: return mk(OP_WR,   '0,        8'h00, 1'b1);
    endcase
  endfunction

  function automatic logic lock_seen(logic [DATA_W-1:0] rd);
    return rd[LOCK_BIT];
  endfunction

  function automatic int flush_len(int div, int periods);
    return div * periods;
  endfunction

endpackage

// File: rtl/trx_seq_flush_timer.sv
module trx_seq_flush_timer #(
  parameter int DIV     = 64,
  parameter int PERIODS = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic ce,
  output logic expire
);
  localparam int PRE_W = (DIV > 1) ? $clog2(DIV) : 1;
  localparam int PER_W = (PERIODS > 1) ? $clog2(PERIODS) : 1;

  logic             active;
  logic [PRE_W-1:0] pre;
  logic [PER_W-1:0] per;
  logic             pre_wrap;
  logic             per_last;

  assign pre_wrap = (pre == PRE_W'(DIV - 1));
  assign per_last = (per == PER_W'(PERIODS - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active <= 1'b0;
      pre    <= '0;
      per    <= '0;
      expire <= 1'b0;
    end else begin
      expire <= 1'b0;
      if (start) begin
        active <= 1'b1;
        pre    <= '0;
        per    <= '0;
      end else if (active && ce) begin
        if (pre_wrap) begin
          pre <= '0;
          if (per_last) begin
            active <= 1'b0;
            expire <= 1'b1;
          end else begin
            per <= per + 1'b1;
          end
        end else begin
          pre <= pre + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/trx_seq_reg_master.sv
module trx_seq_reg_master
  import trx_seq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  input  logic              go_we,
  input  logic [ADDR_W-1:0] go_addr,
  input  logic [DATA_W-1:0] go_wdata,
  output logic              reg_valid,
  output logic              reg_write,
  output logic [ADDR_W-1:0] reg_addr,
  output logic [DATA_W-1:0] reg_wdata,
  input  logic              reg_ready,
  output logic              ack
);
  assign ack = reg_valid & reg_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      reg_valid <= 1'b0;
      reg_write <= 1'b0;
      reg_addr  <= '0;
      reg_wdata <= '0;
    end else if (go && !reg_valid) begin
      reg_valid <= 1'b1;
      reg_write <= go_we;
      reg_addr  <= go_addr;
      reg_wdata <= go_wdata;
    end else if (ack) begin
      reg_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/trx_sleep_sequencer.sv
module trx_sleep_sequencer
  import trx_seq_pkg::*;
#(
  parameter int POLL_MAX      = 256,
  parameter int FLUSH_DIV     = 64,
  parameter int FLUSH_PERIODS = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sleep_req,
  input  logic              wake_req,
  input  logic              smp_ce,
  output logic              reg_valid,
  output logic              reg_write,
  output logic [ADDR_W-1:0] reg_addr,
  output logic [DATA_W-1:0] reg_wdata,
  input  logic              reg_ready,
  input  logic [DATA_W-1:0] reg_rdata,
  output logic              busy,
  output logic              done,
  output logic [1:0]        pwr_state,
  output logic              wake_err
);
  localparam int PC_W = $clog2(POLL_MAX + 1);

  typedef enum logic [1:0] {F_IDLE, F_ISSUE, F_ACK, F_FLUSH} fsm_e;

  fsm_e              fsm;
  pstate_e           pstate;
  logic [STEP_W-1:0] idx;
  logic [PC_W-1:0]   poll_cnt;
  logic              done_q;
  logic              err_q;
  step_t             cur;

  // named internal events
  logic step_ack;
  logic flush_start;
  logic flush_expire;
  logic cmd_go;
  logic lock_ok;
  logic poll_fail;
  logic poll_retry;
  logic accept_sleep;
  logic accept_wake;

  assign cur          = seq_step(idx);
  assign lock_ok      = lock_seen(reg_rdata);
  assign flush_start  = (fsm == F_ISSUE) && (cur.op == OP_WAIT);
  assign cmd_go       = (fsm == F_ISSUE) && (cur.op != OP_WAIT);
  assign poll_retry   = step_ack && (cur.op == OP_POLL) && !lock_ok;
  assign poll_fail    = poll_retry && (poll_cnt == PC_W'(POLL_MAX - 1));
  assign accept_sleep = (fsm == F_IDLE) && sleep_req && (pstate == PS_AWAKE);
  assign accept_wake  = (fsm == F_IDLE) && wake_req && (pstate == PS_ASLEEP);

  trx_seq_reg_master u_master (
    .clk       (clk),
    .rst_n     (rst_n),
    .go        (cmd_go),
    .go_we     (cur.op == OP_WR),
    .go_addr   (cur.addr),
    .go_wdata  (cur.data),
    .reg_valid (reg_valid),
    .reg_write (reg_write),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_ready (reg_ready),
    .ack       (step_ack)
  );

  trx_seq_flush_timer #(
    .DIV     (FLUSH_DIV),
    .PERIODS (FLUSH_PERIODS)
  ) u_flush (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (flush_start),
    .ce     (smp_ce),
    .expire (flush_expire)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fsm      <= F_IDLE;
      pstate   <= PS_AWAKE;
      idx      <= '0;
      poll_cnt <= '0;
      done_q   <= 1'b0;
      err_q    <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (fsm)
        F_IDLE: begin
          if (accept_sleep) begin
            idx    <= '0;
            pstate <= PS_ENTERING;
            fsm    <= F_ISSUE;
          end else if (accept_wake) begin
            idx      <= STEP_W'(WAKE_FIRST);
            pstate   <= PS_WAKING;
            err_q    <= 1'b0;
            poll_cnt <= '0;
            fsm      <= F_ISSUE;
          end
        end
        F_ISSUE: fsm <= (cur.op == OP_WAIT) ? F_FLUSH : F_ACK;
        F_ACK: begin
          if (step_ack) begin
            if (poll_fail) begin
              err_q  <= 1'b1;
              pstate <= PS_ASLEEP;
              done_q <= 1'b1;
              fsm    <= F_IDLE;
            end else if (poll_retry) begin
              poll_cnt <= poll_cnt + 1'b1;
              fsm      <= F_ISSUE;
            end else if (cur.last) begin
              pstate <= (pstate == PS_ENTERING) ? PS_ASLEEP : PS_AWAKE;
              done_q <= 1'b1;
              fsm    <= F_IDLE;
            end else begin
              idx <= idx + 1'b1;
              fsm <= F_ISSUE;
            end
          end
        end
        F_FLUSH: begin
          if (flush_expire) begin
            idx <= idx + 1'b1;
            fsm <= F_ISSUE;
          end
        end
        default: fsm <= F_IDLE;
      endcase
    end
  end

  assign busy      = (fsm != F_IDLE);
  assign done      = done_q;
  assign pwr_state = pstate;
  assign wake_err  = err_q;

endmodule

// File: rtl/trx_sleep_sequencer_chk.sv
module trx_sleep_sequencer_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       sleep_req,
  input logic       wake_req,
  input logic       reg_valid,
  input logic       reg_ready,
  input logic       reg_write,
  input logic [9:0] reg_addr,
  input logic [7:0] reg_wdata,
  input logic       busy,
  input logic       done,
  input logic [1:0] pwr_state,
  input logic       wake_err,
  input logic       flush_expire,
  input logic       poll_fail
);
  assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    reg_valid && !reg_ready |=> reg_valid && $stable(reg_addr) && $stable(reg_wdata) && $stable(reg_write));

  assert_idle_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !reg_valid);

  assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  assert_busy_state_R9: assert property (@(posedge clk) disable iff (!rst_n)
    busy == pwr_state[0]);

  assert_err_asleep_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wake_err |-> pwr_state == 2'b10);

  assert_fail_waking_R5: assert property (@(posedge clk) disable iff (!rst_n)
    poll_fail |=> done && wake_err);

  assert_flush_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
    flush_expire |-> busy && !reg_valid && pwr_state == 2'b01);

  assert_sleep_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && sleep_req && !wake_req && pwr_state != 2'b00 |=> !busy && $stable(pwr_state));

  assert_wake_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && wake_req && !sleep_req && pwr_state != 2'b10 |=> !busy && $stable(pwr_state));
endmodule

bind trx_sleep_sequencer trx_sleep_sequencer_chk chk_i (
  .clk          (clk),
  .rst_n        (rst_n),
  .sleep_req    (sleep_req),
  .wake_req     (wake_req),
  .reg_valid    (reg_valid),
  .reg_ready    (reg_ready),
  .reg_write    (reg_write),
  .reg_addr     (reg_addr),
  .reg_wdata    (reg_wdata),
  .busy         (busy),
  .done         (done),
  .pwr_state    (pwr_state),
  .wake_err     (wake_err),
  .flush_expire (flush_expire),
  .poll_fail    (poll_fail)
);

// File: tb/trx_sleep_sequencer_tb_top.sv
`timescale 1ns/1ps
module trx_sleep_sequencer_tb_top;
  localparam int PMAX = 4;
  localparam int FLUSH = 64 * 6;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sleep_req = 1'b0;
  logic       wake_req = 1'b0;
  logic       smp_ce = 1'b0;
  logic       reg_valid, reg_write;
  logic [9:0] reg_addr;
  logic [7:0] reg_wdata;
  logic       reg_ready = 1'b0;
  logic [7:0] reg_rdata = 8'h00;
  logic       busy, done, wake_err;
  logic [1:0] pwr_state;

  always #4 clk = ~clk;

  trx_sleep_sequencer #(.POLL_MAX(PMAX)) dut_i (
    .clk(clk), .rst_n(rst_n), .sleep_req(sleep_req), .wake_req(wake_req),
    .smp_ce(smp_ce), .reg_valid(reg_valid), .reg_write(reg_write),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_ready(reg_ready),
    .reg_rdata(reg_rdata), .busy(busy), .done(done), .pwr_state(pwr_state),
    .wake_err(wake_err)
  );

  int n_chk = 0;
  int n_bad = 0;

  // slave model and monitor state
  int lat = 0, wcnt = 0, ce_div = 1, cyc = 0, ce_cnt = 0;
  int lock_after = 1, reads = 0, done_cnt = 0;
  int nlog = 0;
  logic [9:0] l_addr [64];
  logic [7:0] l_data [64];
  logic       l_we   [64];
  int         ce_at  [64];
  int nexp = 0;
  logic [9:0] e_addr [64];
  logic [7:0] e_data [64];
  logic       e_we   [64];

  always @(negedge clk) begin
    cyc = cyc + 1;
    if (done) done_cnt = done_cnt + 1;
    if (reg_ready) begin
      reg_ready = 1'b0;
    end else if (reg_valid) begin
      if (wcnt >= lat) begin
        reg_ready = 1'b1;
        wcnt = 0;
        if (nlog < 64) begin
          l_addr[nlog] = reg_addr; l_data[nlog] = reg_wdata;
          l_we[nlog] = reg_write; ce_at[nlog] = ce_cnt;
          nlog = nlog + 1;
        end
        if (!reg_write) begin
          reads = reads + 1;
          reg_rdata = (lock_after != 0 && reads >= lock_after) ? 8'h80 : 8'h7F;
        end
      end else begin
        wcnt = wcnt + 1;
      end
    end
    smp_ce = (ce_div <= 1) ? 1'b1 : ((cyc % ce_div) == 0);
    if (smp_ce) ce_cnt = ce_cnt + 1;
  end

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic push(input logic we, input logic [9:0] a, input logic [7:0] d);
    e_we[nexp] = we; e_addr[nexp] = a; e_data[nexp] = d; nexp++;
  endtask

  task automatic cmp_log(input string req);
    int bad_at;
    bad_at = -1;
    for (int i = 0; i < nexp && i < nlog; i++)
      if (bad_at < 0 && (l_we[i] != e_we[i] || l_addr[i] != e_addr[i] ||
          (e_we[i] && l_data[i] != e_data[i]))) bad_at = i;
    check(nlog == nexp, req, "access count", nlog, nexp);
    if (bad_at >= 0)
      check(1'b0, req, "access addr/data", {l_addr[bad_at], l_data[bad_at]}, {e_addr[bad_at], e_data[bad_at]});
    else
      check(1'b1, req, "access order", 0, 0);
  endtask

  task automatic clear_log();
    nlog = 0; nexp = 0; reads = 0;
  endtask

  // runs one command and waits for its done pulse; poke injects stray commands mid-run
  task automatic run_cmd(input bit do_sleep, input bit poke);
    int d0;
    bit seen;
    d0 = done_cnt;
    seen = 0;
    @(negedge clk);
    sleep_req = do_sleep; wake_req = !do_sleep;
    @(negedge clk);
    sleep_req = 0; wake_req = 0;
    for (int k = 0; k < 6000 && !seen; k++) begin
      @(negedge clk);
      sleep_req = poke && (k == 10 || k == 500);
      wake_req  = poke && (k == 10 || k == 600);
      if (done_cnt != d0) seen = 1;
    end
    sleep_req = 0; wake_req = 0;
    check(seen, "R9", "done seen", seen, 1);
    repeat (3) @(negedge clk);
    check(done_cnt == d0 + 1, "R9", "single done pulse", done_cnt - d0, 1);
    check(!busy, "R9", "busy low after done", busy, 0);
  endtask

  task automatic do_sleep(input int l, input int cd, input bit poke);
    int diff;
    lat = l; ce_div = cd;
    clear_log();
    push(1, 10'h230, 8'h55); push(1, 10'h270, 8'h55);
    push(1, 10'h014, 8'h00); push(1, 10'h014, 8'h20);
    push(1, 10'h014, 8'h00); push(1, 10'h009, 8'h00);
    run_cmd(1'b1, poke);
    cmp_log(poke ? "R8" : "R2");
    check(pwr_state == 2'b10, "R2", "state asleep", pwr_state, 2'b10);
    if (nlog >= 5) begin
      diff = ce_at[4] - ce_at[3];
      if (cd <= 1)
        check(diff == FLUSH + 4 + l, "R3", "flush ce count", diff, FLUSH + 4 + l);
      else
        check(diff >= FLUSH && diff <= FLUSH + 4 + l, "R3", "flush ce range", diff, FLUSH);
    end
  endtask

  task automatic do_wake(input int l, input int la);
    int nr;
    bit ok;
    lat = l; lock_after = la;
    clear_log();
    ok = (la >= 1 && la <= PMAX);
    nr = ok ? la : PMAX;
    push(1, 10'h009, 8'h17);
    for (int i = 0; i < nr; i++) push(0, 10'h05E, 8'h00);
    if (ok) begin
      push(1, 10'h014, 8'h05); push(1, 10'h230, 8'h54); push(1, 10'h270, 8'h54);
    end
    run_cmd(1'b0, 1'b0);
    cmp_log(ok ? "R4" : "R5");
    check(pwr_state == (ok ? 2'b00 : 2'b10), ok ? "R4" : "R5", "final state", pwr_state, ok ? 0 : 2);
    check(wake_err == !ok, "R5", "wake_err", wake_err, !ok);
  endtask

  task automatic ignored(input bit do_sleep, input string req);
    logic [1:0] s0;
    s0 = pwr_state;
    clear_log();
    @(negedge clk);
    sleep_req = do_sleep; wake_req = !do_sleep;
    @(negedge clk);
    sleep_req = 0; wake_req = 0;
    repeat (20) @(negedge clk);
    check(nlog == 0, req, "no access when ignored", nlog, 0);
    check(pwr_state == s0 && !busy, req, "state unchanged", pwr_state, s0);
  endtask

  initial begin
    #(200000 * 8);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(!busy && !done && !wake_err && !reg_valid && pwr_state == 2'b00, "R1",
          "reset state", {busy, done, wake_err, reg_valid, pwr_state}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    ignored(1'b0, "R7");               // wake while awake
    do_sleep(0, 1, 1'b0);              // exact flush count
    ignored(1'b1, "R7");               // sleep while asleep
    do_wake(2, 3);
    do_sleep(1, 1, 1'b1);              // stray commands mid-run (R8)
    check(wake_err == 0, "R8", "no error from stray", wake_err, 0);
    do_wake(1, 0);                     // never locks
    do_wake(0, PMAX);                  // lock on last allowed read, clears error
    for (int l = 0; l < 4; l++)
      for (int la = 1; la <= PMAX; la++) begin
        do_sleep(l, 1 + (la % 3), 1'b0);
        do_wake(l, la);
      end
    do_sleep(3, 2, 1'b0);
    do_wake(3, PMAX + 1);              // lock one read too late

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule